// File: doc/BRIEF.md
# Synchronous Operand Bus Master

This block sits between an internal requester and a synchronous external bus. The requester hands over one operand at a time: a 32-bit byte address, a byte count from one to four, a direction and, for writes, the data. The block turns the operand into one or more bus cycles. Each cycle starts with a one-clock start strobe and ends when the external target acknowledges. An operand that crosses a 32-bit word boundary is split into several cycles. Each cycle after the first begins at the next word-aligned address.

The size output does not give the bytes moved in the current cycle. It gives the bytes still outstanding in the whole operand, and it is refreshed at the start of every cycle. The read/write line is left alone between cycles and moves only when an operand of the opposite direction begins. On reads, the bytes returned by each cycle are collected into an operand register. A one-clock completion pulse presents the collected value after the final acknowledge.

All inputs are sampled on the rising clock edge. Every output comes from a register or from a state decode, so no output has a combinational path from any input.

Top module: `ext_bus_master`

## Requirements
- R1: `req_ready` is 1 only while the master is idle. An operand is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_nbytes` must be 1 to 4.
- R2: `bus_ts` is high for exactly one clock at the start of every bus cycle. The first cycle of an operand starts in the clock right after the operand is taken.
- R3: `bus_ta` is ignored during the clock in which `bus_ts` is high. A cycle ends on the first later edge where `bus_ta` is 1, so every cycle lasts at least two clocks. `bus_addr`, `bus_tsize` and `bus_rdwr` hold steady until that edge.
- R4: `bus_tsize` encodes the bytes still to move in the operand, including the current cycle: 1 gives 01, 2 gives 10, 3 gives 11, 4 gives 00. It reads 00 while idle.
- R5: Each cycle moves min(remaining bytes, 4 − `bus_addr[1:0]`) bytes. A cycle after the first starts at the next word-aligned address. The first cycle uses the request address unchanged.
- R6: `bus_rdwr` is 1 for a read and 0 for a write, and it is 1 after reset. It changes only on the edge that takes an operand of the other direction. Otherwise it holds, idle periods included.
- R7: Operand byte k is bits [8k+7:8k] of the operand word. Bus lane j is bits [8j+7:8j] of the data bus. On writes, a cycle that starts at operand byte i puts operand byte i+m on lane `bus_addr[1:0]`+m. Lanes outside the transfer, and all lanes while idle or reading, are 0.
- R8: On reads, the lanes of each acknowledged cycle fill the matching operand bytes, using the mapping of R7. `done` is high for one clock, starting the clock after the final acknowledge. `done_rdata` then shows the collected operand, with bytes beyond the count set to 0.
- R9: After reset, `req_ready`=1, `bus_ts`=0, `done`=0, `bus_rdwr`=1, `bus_tsize`=00 and `bus_addr`=0.
- R10: The master is idle again, with `req_ready`=1, in the clock after the final acknowledge. An operand held valid back to back is taken on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Master idle and able to take a request |
| req_addr | input | 32 | Byte address of the first operand byte |
| req_nbytes | input | 3 | Operand length in bytes, 1 to 4 |
| req_write | input | 1 | 1 = write operand, 0 = read operand |
| req_wdata | input | 32 | Write operand, byte k in bits [8k+7:8k] |
| bus_addr | output | 32 | Address of the current bus cycle |
| bus_tsize | output | 2 | Bytes left in the operand (encoding per R4) |
| bus_rdwr | output | 1 | 1 = read, 0 = write |
| bus_ts | output | 1 | One-clock start strobe of a bus cycle |
| bus_wdata | output | 32 | Byte-lane steered write data |
| bus_rdata | input | 32 | Read data from the target, lane j in bits [8j+7:8j] |
| bus_ta | input | 1 | Transfer acknowledge from the target |
| done | output | 1 | One-clock operand completion pulse |
| done_rdata | output | 32 | Collected read operand, valid while `done` is 1 |

## Verification
A wrong remaining count appears at `bus_tsize` in the strobe clock of the affected cycle. It also changes the number of strobes, so an extra or missing cycle shows up within one acknowledge. A bad lane offset or operand byte index appears on `bus_wdata` in the same clock on writes. On reads it stays hidden until `done`, a few clocks later. A direction register that toggles wrongly shows on `bus_rdwr` at once, even while idle. A state register stuck in wait shows as a missing `req_ready` in the clock after the final acknowledge. Every output is therefore compared with a behavioural model on every clock, with random acknowledge delays and stray acknowledges during strobe clocks.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

    typedef enum logic [1:0] {
        EBM_IDLE  = 2'd0,
        EBM_START = 2'd1,
        EBM_WAIT  = 2'd2
    } ebm_state_e;

    // Remaining-bytes code: the full lane count wraps to all zeros.
    function automatic logic [1:0] ebm_size_code(input logic [2:0] remaining);
        return remaining[1:0];
    endfunction

endpackage

// File: rtl/ebm_split.sv
module ebm_split #(
    parameter int LANES = 4,
    parameter int OFF_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [OFF_W-1:0] off,
    input  logic [CNT_W-1:0] remaining,
    output logic [CNT_W-1:0] nbytes,
    output logic             last
);
    logic [CNT_W:0] room;
    logic [CNT_W:0] rem_ext;

    always_comb begin
        room    = (CNT_W+1)'(LANES) - (CNT_W+1)'(off);
        rem_ext = {1'b0, remaining};
        if (rem_ext <= room) begin
            nbytes = remaining;
        end else begin
            nbytes = room[CNT_W-1:0];
        end
        last = (nbytes == remaining);
    end
endmodule

// File: rtl/ebm_lanes.sv
module ebm_lanes #(
    parameter int LANES = 4,
    parameter int OFF_W = 2,
    parameter int CNT_W = 3
) (
    input  logic [OFF_W-1:0]   off,
    input  logic [CNT_W-1:0]   idx,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic [8*LANES-1:0] opnd,
    input  logic [8*LANES-1:0] rdata,
    output logic [8*LANES-1:0] wdata,
    output logic [8*LANES-1:0] merged
);
    logic             hit [LANES];
    logic [OFF_W-1:0] sel [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [CNT_W:0] rel;
        logic [CNT_W:0] pos;
        always_comb begin
            rel = (CNT_W+1)'(j) - (CNT_W+1)'(off);
            pos = rel + {1'b0, idx};
        end
        assign hit[j] = ((CNT_W+1)'(j) >= (CNT_W+1)'(off)) && (rel < {1'b0, nbytes});
        assign sel[j] = pos[OFF_W-1:0];
        assign wdata[8*j +: 8] = hit[j] ? opnd[8*sel[j] +: 8] : 8'h00;
    end

    always_comb begin
        merged = opnd;
        for (int j = 0; j < LANES; j++) begin
            if (hit[j]) begin
                merged[8*sel[j] +: 8] = rdata[8*j +: 8];
            end
        end
    end
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master
    import ebm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_nbytes,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_tsize,
    output logic              bus_rdwr,
    output logic              bus_ts,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ta,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = $clog2(LANES + 1);

    typedef struct packed {
        ebm_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  idx;
        logic              wr;
        logic              rdwr;
        logic [DATA_W-1:0] opnd;
        logic              done;
    } ebm_regs_t;

    ebm_regs_t r_q, r_d;

    logic [CNT_W-1:0]  cyc_bytes;
    logic              cyc_last;
    logic [DATA_W-1:0] lane_wdata;
    logic [DATA_W-1:0] lane_merged;

    ebm_split #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_split (
        .off       (r_q.addr[OFF_W-1:0]),
        .remaining (r_q.rem),
        .nbytes    (cyc_bytes),
        .last      (cyc_last)
    );

    ebm_lanes #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_lanes (
        .off    (r_q.addr[OFF_W-1:0]),
        .idx    (r_q.idx),
        .nbytes (cyc_bytes),
        .opnd   (r_q.opnd),
        .rdata  (bus_rdata),
        .wdata  (lane_wdata),
        .merged (lane_merged)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            EBM_IDLE: begin
                if (req_valid) begin
                    r_d.st   = EBM_START;
                    r_d.addr = req_addr;
                    r_d.rem  = CNT_W'(req_nbytes);
                    r_d.idx  = '0;
                    r_d.wr   = req_write;
                    r_d.rdwr = ~req_write;
                    r_d.opnd = req_write ? req_wdata : '0;
                end
            end
            EBM_START: begin
                r_d.st = EBM_WAIT;
            end
            EBM_WAIT: begin
                if (bus_ta) begin
                    if (!r_q.wr) begin
                        r_d.opnd = lane_merged;
                    end
                    r_d.rem = r_q.rem - cyc_bytes;
                    r_d.idx = r_q.idx + cyc_bytes;
                    if (cyc_last) begin
                        r_d.st   = EBM_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = EBM_START;
                        r_d.addr = {r_q.addr[ADDR_W-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};
                    end
                end
            end
            default: r_d.st = EBM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= EBM_IDLE;
            r_q.rdwr <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == EBM_IDLE);
    assign bus_ts     = (r_q.st == EBM_START);
    assign bus_addr   = r_q.addr;
    assign bus_tsize  = ebm_size_code(3'(r_q.rem));
    assign bus_rdwr   = r_q.rdwr;
    assign bus_wdata  = (r_q.wr && r_q.st != EBM_IDLE) ? lane_wdata : '0;
    assign done       = r_q.done;
    assign done_rdata = r_q.opnd;

    // R1: only legal operand lengths are taken
    p_len_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_nbytes >= 3'd1 && req_nbytes <= 3'd4));

    // R2: strobe lasts a single clock
    p_ts_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ts |=> !bus_ts);

    // R10: an accepted operand strobes in the next clock
    p_accept_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_ts);

    // R3: cycle attributes held while no acknowledge is seen
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !bus_ts && !bus_ta) |=>
            ($stable(bus_addr) && $stable(bus_tsize) && $stable(bus_rdwr)));

    // R6: direction only moves on an accepting edge
    p_rdwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $stable(bus_rdwr));

    // R5: a follow-on cycle starts word aligned
    p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == EBM_WAIT && bus_ta && !cyc_last) |=>
            (bus_ts && bus_addr[OFF_W-1:0] == '0));

    // R8: completion follows an acknowledge and is one clock wide
    p_done_after_ta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_ta) && req_ready));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_ext_bus_master.sv
module sim_ext_bus_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_nbytes = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] bus_addr;
    logic [1:0]  bus_tsize;
    logic        bus_rdwr;
    logic        bus_ts;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ta = 1'b0;
    logic        done;
    logic [31:0] done_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_master u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_nbytes(req_nbytes),
        .req_write(req_write), .req_wdata(req_wdata),
        .bus_addr(bus_addr), .bus_tsize(bus_tsize), .bus_rdwr(bus_rdwr),
        .bus_ts(bus_ts), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ta(bus_ta), .done(done), .done_rdata(done_rdata)
    );

    // Behavioural reference model, advanced on every rising edge
    int          ph;
    logic [31:0] m_addr;
    int          m_rem;
    int          m_idx;
    bit          m_wr;
    bit          m_rdwr;
    logic [31:0] m_op;
    bit          m_done;

    function automatic int chunk(logic [31:0] a, int rem);
        int room;
        room = 4 - int'(a[1:0]);
        return (rem < room) ? rem : room;
    endfunction

    always @(posedge clk) begin : model
        if (!rst_n) begin
            ph = 0; m_addr = '0; m_rem = 0; m_idx = 0;
            m_wr = 1'b0; m_rdwr = 1'b1; m_op = '0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (ph == 0) begin
                if (req_valid) begin
                    m_addr = req_addr; m_rem = int'(req_nbytes); m_idx = 0;
                    m_wr = req_write; m_rdwr = !req_write;
                    m_op = req_write ? req_wdata : 32'h0;
                    ph = 1;
                end
            end else if (ph == 1) begin
                ph = 2;
            end else if (bus_ta) begin
                int off;
                int n;
                off = int'(m_addr[1:0]);
                n = chunk(m_addr, m_rem);
                if (!m_wr)
                    for (int i = 0; i < n; i++)
                        m_op[8*(m_idx+i) +: 8] = bus_rdata[8*(off+i) +: 8];
                m_rem -= n;
                m_idx += n;
                if (m_rem == 0) begin
                    ph = 0; m_done = 1'b1;
                end else begin
                    m_addr = (m_addr & ~32'h3) + 32'd4;
                    ph = 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_wdata();
        logic [31:0] w;
        int off;
        int n;
        w = '0;
        if (ph != 0 && m_wr) begin
            off = int'(m_addr[1:0]);
            n = chunk(m_addr, m_rem);
            for (int i = 0; i < n; i++)
                w[8*(off+i) +: 8] = m_op[8*(m_idx+i) +: 8];
        end
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin : compare
        if (chk_en && !finished) begin
            chk("R1 R10 req_ready", 32'(req_ready), 32'(ph == 0));
            chk("R2 bus_ts", 32'(bus_ts), 32'(ph == 1));
            chk("R3 R5 bus_addr", bus_addr, m_addr);
            chk("R3 R4 bus_tsize", 32'(bus_tsize), 32'(m_rem % 4));
            chk("R6 bus_rdwr", 32'(bus_rdwr), 32'(m_rdwr));
            chk("R7 bus_wdata", bus_wdata, exp_wdata());
            chk("R8 done", 32'(done), 32'(m_done));
            if (m_done) chk("R8 done_rdata", done_rdata, m_op);
        end
    end

    // Target: random wait states, stray acknowledges during strobe clocks
    int ta_cnt = 0;
    bit ta_busy = 1'b0;
    always @(negedge clk) begin : target
        bus_rdata = $urandom;
        if (!rst_n) begin
            bus_ta = 1'b0; ta_busy = 1'b0; ta_cnt = 0;
        end else if (bus_ts) begin
            ta_cnt = $urandom % 4;
            ta_busy = 1'b1;
            bus_ta = (($urandom % 3) == 0);
        end else if (ta_busy) begin
            if (ta_cnt == 0) begin
                bus_ta = 1'b1; ta_busy = 1'b0;
            end else begin
                ta_cnt--; bus_ta = 1'b0;
            end
        end else begin
            bus_ta = (($urandom % 5) == 0);
        end
    end

    task automatic issue(logic [31:0] a, int n, bit wr, logic [31:0] d);
        req_valid = 1'b1; req_addr = a; req_nbytes = 3'(n);
        req_write = wr; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset values at the ports
        chk("R9 ready", 32'(req_ready), 32'd1);
        chk("R9 ts", 32'(bus_ts), 32'd0);
        chk("R9 done", 32'(done), 32'd0);
        chk("R9 rdwr", 32'(bus_rdwr), 32'd1);
        chk("R9 tsize", 32'(bus_tsize), 32'd0);
        chk("R9 addr", bus_addr, 32'd0);
        chk_en = 1'b1;
        repeat (3) @(negedge clk);
        // Directed operands: aligned, straddling, every offset
        issue(32'h0000_1000, 4, 1'b0, 32'h0);
        issue(32'h0000_2001, 4, 1'b0, 32'h0);
        issue(32'h0000_3003, 2, 1'b1, 32'hA5A5_1234);
        issue(32'h0000_3102, 2, 1'b1, 32'h0000_BEEF);
        issue(32'h0000_3201, 1, 1'b0, 32'h0);
        issue(32'h0000_3302, 3, 1'b0, 32'h0);
        issue(32'h0000_3403, 4, 1'b1, 32'hDEAD_BEEF);
        issue(32'h0000_3503, 4, 1'b1, 32'h0102_0304);
        issue(32'h0000_3600, 1, 1'b1, 32'h0000_0077);
        repeat (4) @(negedge clk);
        // Random operands, some back to back, some with idle gaps
        for (int k = 0; k < 80; k++) begin
            issue($urandom, 1 + ($urandom % 4), bit'($urandom % 2), $urandom);
            repeat ($urandom % 3) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule